// File: doc/BRIEF.md
# Wait-on-Reservation Stall Controller

This block sits beside a hart's issue stage and handles the two wait-on-reservation instructions. A wait instruction is offered on a valid/ready issue port. When it is accepted while the hart holds a live reservation and no interrupt line is raised, the block holds `stall` high, so the hart idles in a low-power wait. The wait ends on one of five events: loss of the reservation, any raised interrupt line, a spontaneous wake request, expiry of the short bound for the bounded variant, or expiry of the trap limit for the unbounded variant when the privilege context makes the wait trappable. The block then gives a one-cycle pulse on exactly one of `done`, `illegal_exc` or `virtual_exc`.

Reservation state is kept in the block. `lr_set` marks it live. `snoop_hit` kills it; this input carries the result of an address match made elsewhere for a store to the reserved bytes. `resv_clear` also kills it. Interrupt lines count whether or not they are enabled. Back-pressure: `issue_ready` is high only when no wait is in progress. A word is taken on any cycle with `issue_valid` and `issue_ready` both high. Words that are not wait instructions are taken and have no effect. The privilege inputs are sampled at the moment of acceptance.

Top module: `wrs_stall_ctrl`

## Requirements
- R1: A word is a wait instruction only when bits [6:0]=0x73, bits [11:7]=0, bits [14:12]=0, bits [19:15]=0 and bits [31:20] are 0x00D (unbounded) or 0x01D (bounded). Any other accepted word changes neither `stall` nor any result output, and it leaves the reservation as it was.
- R2: The reservation becomes live one cycle after `lr_set`. It becomes dead one cycle after `snoop_hit` or `resv_clear`. When a kill input and `lr_set` arrive in the same cycle, the kill wins.
- R3: When a wait instruction is accepted while the reservation is dead, is being killed in that cycle, or any `irq_pending` bit is high, `done` pulses in the next cycle and `stall` stays low.
- R4: Otherwise, `stall` is high from the cycle after acceptance, and `issue_ready` is low for as long as `stall` is high.
- R5: A `snoop_hit` or `resv_clear` during a stall drops `stall` and pulses `done` in the next cycle.
- R6: Any high `irq_pending` bit during a stall drops `stall` and pulses `done` in the next cycle, with no enable involved.
- R7: A bounded wait with no other wake event stays stalled for exactly STO_CYCLES cycles and then pulses `done`.
- R8: An unbounded wait with `tw_bit`=1 and `priv_mode` not M (M=2'b11, S=2'b01, U=2'b00), and with no wake event, stays stalled for exactly TRAP_CYCLES cycles and then pulses `illegal_exc` instead of `done`.
- R9: An unbounded wait with `tw_bit`=0, `vtw_bit`=1, `virt_mode`=1 and `priv_mode` U or S pulses `virtual_exc` after TRAP_CYCLES stall cycles. When `tw_bit`=1, the illegal-instruction result wins.
- R10: An unbounded wait in M mode, or one with `tw_bit`=0 and no virtual trap condition, never times out or traps. It stays stalled until a wake event.
- R11: `early_wake` during a stall drops `stall` and pulses `done` in the next cycle.
- R12: A wake event in the last cycle before a bound or limit expires gives `done`, not an exception. At most one of `done`, `illegal_exc`, `virtual_exc` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction word offered |
| issue_ready | output | 1 | Block can take a word (no wait in progress) |
| issue_insn | input | 32 | Instruction word |
| priv_mode | input | 2 | Privilege at issue: 00 U, 01 S, 11 M |
| virt_mode | input | 1 | Hart runs virtualized at issue |
| tw_bit | input | 1 | Machine-level timeout-wait control |
| vtw_bit | input | 1 | Hypervisor-level timeout-wait control |
| lr_set | input | 1 | Load-reserved made a new reservation |
| snoop_hit | input | 1 | Store matched the reserved bytes |
| resv_clear | input | 1 | Reservation dropped for another reason |
| irq_pending | input | NUM_IRQ | Pending interrupt lines, enabled or not |
| early_wake | input | 1 | Spontaneous wake request |
| stall | output | 1 | Hart held in low-power wait |
| done | output | 1 | One-cycle pulse: wait instruction completed |
| illegal_exc | output | 1 | One-cycle pulse: illegal-instruction trap |
| virtual_exc | output | 1 | One-cycle pulse: virtual-instruction trap |

## Verification
Waits are issued with the reservation dead, killed in the acceptance cycle, or live with an interrupt raised. These show the immediate path apart from a true stall. Live waits are ended in turn by a snoop, an interrupt, an early wake, the short bound and the trap limit, and the stall length is counted each time. This shows which wake source ended the wait and whether the bound was exact. The privilege, virtualization and control-bit combinations are walked so that an illegal trap, a virtual trap and an endless wait can each be told apart. Near-miss encodings and a wake in the same cycle as a limit check the decoding and the precedence of completion over a trap.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  localparam logic [6:0]  OPC_SYSTEM = 7'h73;
  localparam logic [11:0] F12_NTO    = 12'h00D;
  localparam logic [11:0] F12_STO    = 12'h01D;
  localparam logic [1:0]  PRV_U      = 2'b00;
  localparam logic [1:0]  PRV_S      = 2'b01;
  localparam logic [1:0]  PRV_M      = 2'b11;

  typedef enum logic [1:0] {TRAP_NONE, TRAP_ILL, TRAP_VIRT} trap_e;
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;
endpackage

// File: rtl/wrs_decode.sv
module wrs_decode
  import wrs_pkg::*;
(
  input  logic [31:0] insn,
  input  logic [1:0]  priv_mode,
  input  logic        virt_mode,
  input  logic        tw_bit,
  input  logic        vtw_bit,
  output logic        is_wrs,
  output logic        is_sto,
  output trap_e       trap_kind
);
  logic fixed_ok, nto_hit, sto_hit, below_m;

  always_comb begin
    fixed_ok = (insn[6:0] == OPC_SYSTEM) && (insn[11:7] == 5'd0) &&
               (insn[14:12] == 3'd0) && (insn[19:15] == 5'd0);
    nto_hit  = fixed_ok && (insn[31:20] == F12_NTO);
    sto_hit  = fixed_ok && (insn[31:20] == F12_STO);
    is_wrs   = nto_hit || sto_hit;
    is_sto   = sto_hit;
    below_m  = (priv_mode != PRV_M);
    // Only the unbounded variant can trap; the machine-level bit wins.
    if (nto_hit && tw_bit && below_m)
      trap_kind = TRAP_ILL;
    else if (nto_hit && !tw_bit && vtw_bit && virt_mode && below_m)
      trap_kind = TRAP_VIRT;
    else
      trap_kind = TRAP_NONE;
  end
endmodule

// File: rtl/wrs_resv_track.sv
module wrs_resv_track (
  input  logic clk,
  input  logic rst_n,
  input  logic lr_set,
  input  logic kill,
  output logic resv_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n)      resv_valid <= 1'b0;
    else if (kill)   resv_valid <= 1'b0;
    else if (lr_set) resv_valid <= 1'b1;
  end

  a_r2_kill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !resv_valid);
  a_r2_lr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_set && !kill) |=> resv_valid);
endmodule

// File: rtl/wrs_wait_timer.sv
module wrs_wait_timer #(
  parameter int STO_CYCLES  = 24,
  parameter int TRAP_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sto_expire,
  output logic trap_expire
);
  localparam int CMAX = ((STO_CYCLES > TRAP_CYCLES) ? STO_CYCLES : TRAP_CYCLES) - 1;
  localparam int CW   = $clog2(CMAX + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt <= '0;
    else if (start)                      cnt <= '0;
    else if (run && cnt != CW'(CMAX))    cnt <= cnt + 1'b1;
  end

  assign sto_expire  = run && (cnt == CW'(STO_CYCLES - 1));
  assign trap_expire = run && (cnt == CW'(TRAP_CYCLES - 1));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0));
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CMAX));
endmodule

// File: rtl/wrs_stall_ctrl.sv
module wrs_stall_ctrl
  import wrs_pkg::*;
#(
  parameter int NUM_IRQ     = 4,
  parameter int STO_CYCLES  = 24,
  parameter int TRAP_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  output logic               issue_ready,
  input  logic [31:0]        issue_insn,
  input  logic [1:0]         priv_mode,
  input  logic               virt_mode,
  input  logic               tw_bit,
  input  logic               vtw_bit,
  input  logic               lr_set,
  input  logic               snoop_hit,
  input  logic               resv_clear,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic               early_wake,
  output logic               stall,
  output logic               done,
  output logic               illegal_exc,
  output logic               virtual_exc
);
  state_e state_q;
  trap_e  trap_q, dec_trap;
  logic   sto_q, dec_wrs, dec_sto;
  logic   resv_valid, resv_kill, resv_ok, irq_any;
  logic   accept, go_wait, wake, sto_exp, trap_exp;
  logic   done_q, ill_q, virt_q;

  wrs_decode u_dec (
    .insn(issue_insn), .priv_mode(priv_mode), .virt_mode(virt_mode),
    .tw_bit(tw_bit), .vtw_bit(vtw_bit),
    .is_wrs(dec_wrs), .is_sto(dec_sto), .trap_kind(dec_trap)
  );

  assign resv_kill = snoop_hit || resv_clear;

  wrs_resv_track u_resv (
    .clk(clk), .rst_n(rst_n), .lr_set(lr_set), .kill(resv_kill),
    .resv_valid(resv_valid)
  );

  assign resv_ok     = resv_valid && !resv_kill;
  assign irq_any     = |irq_pending;
  assign issue_ready = (state_q == ST_IDLE);
  assign accept      = issue_valid && issue_ready && dec_wrs;
  assign go_wait     = accept && resv_ok && !irq_any;
  assign wake        = !resv_ok || irq_any || early_wake;

  wrs_wait_timer #(.STO_CYCLES(STO_CYCLES), .TRAP_CYCLES(TRAP_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(go_wait), .run(state_q == ST_WAIT),
    .sto_expire(sto_exp), .trap_expire(trap_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trap_q  <= TRAP_NONE;
      sto_q   <= 1'b0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
      virt_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      virt_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go_wait) begin
            state_q <= ST_WAIT;
            sto_q   <= dec_sto;
            trap_q  <= dec_trap;
          end else if (accept) begin
            done_q <= 1'b1;
          end
        end
        ST_WAIT: begin
          // Completion has precedence over a bound or a trap limit.
          if (wake || (sto_q && sto_exp)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (!sto_q && trap_exp && trap_q != TRAP_NONE) begin
            state_q <= ST_IDLE;
            ill_q   <= (trap_q == TRAP_ILL);
            virt_q  <= (trap_q == TRAP_VIRT);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stall       = (state_q == ST_WAIT);
  assign done        = done_q;
  assign illegal_exc = ill_q;
  assign virtual_exc = virt_q;

  a_r3_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (!resv_ok || irq_any)) |=> (done && !stall));
  a_r4_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && dec_wrs && resv_valid && !resv_kill && !irq_any) |=> stall);
  a_r5_resv_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && resv_kill) |=> (!stall && done));
  a_r6_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && irq_any) |=> (!stall && done));
  a_r11_early: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && early_wake) |=> (!stall && done));
  a_r12_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, illegal_exc, virtual_exc}));
  a_r8_trap_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_exc || virtual_exc) |-> $past(stall));
endmodule

// File: tb/wrs_stall_ctrl_tb_top.sv
module wrs_stall_ctrl_tb_top;
  localparam int NIRQ = 4;
  localparam int STO  = 24;
  localparam int TRAP = 64;
  localparam logic [31:0] W_NTO = 32'h00D00073;
  localparam logic [31:0] W_STO = 32'h01D00073;
  localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 1'b0, virt_mode = 1'b0, tw_bit = 1'b0, vtw_bit = 1'b0;
  logic [31:0] issue_insn = '0;
  logic [1:0] priv_mode = 2'b11;
  logic lr_set = 1'b0, snoop_hit = 1'b0, resv_clear = 1'b0, early_wake = 1'b0;
  logic [NIRQ-1:0] irq_pending = '0;
  logic issue_ready, stall, done, illegal_exc, virtual_exc;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wrs_stall_ctrl #(.NUM_IRQ(NIRQ), .STO_CYCLES(STO), .TRAP_CYCLES(TRAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_insn(issue_insn), .priv_mode(priv_mode), .virt_mode(virt_mode),
    .tw_bit(tw_bit), .vtw_bit(vtw_bit), .lr_set(lr_set), .snoop_hit(snoop_hit),
    .resv_clear(resv_clear), .irq_pending(irq_pending), .early_wake(early_wake),
    .stall(stall), .done(done), .illegal_exc(illegal_exc), .virtual_exc(virtual_exc)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic results(string req, int d, int il, int vi);
    check(req, int'(done), d);
    check(req, int'(illegal_exc), il);
    check(req, int'(virtual_exc), vi);
  endtask

  task automatic give_lr();
    lr_set = 1'b1; @(negedge clk); lr_set = 1'b0;
  endtask

  task automatic issue(logic [31:0] w, logic [1:0] p, logic v, logic tw, logic vtw);
    issue_insn = w; priv_mode = p; virt_mode = v; tw_bit = tw; vtw_bit = vtw;
    issue_valid = 1'b1; @(negedge clk); issue_valid = 1'b0;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (stall && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R4 reset stall", int'(stall), 0);
    check("R4 reset ready", int'(issue_ready), 1);
    results("R12 reset results", 0, 0, 0);
  endtask

  task automatic t_decode();
    logic [31:0] bad_w[4] = '{32'h00D000F3, 32'h00E00073, 32'h00D00033, 32'h00D01073};
    give_lr();
    foreach (bad_w[i]) begin
      issue(bad_w[i], PM, 1'b0, 1'b0, 1'b0);
      check("R1 non-wait word stall", int'(stall), 0);
      results("R1 non-wait word results", 0, 0, 0);
    end
    issue(W_NTO, PM, 1'b0, 1'b0, 1'b0);
    check("R1 reservation untouched, stall", int'(stall), 1);
    check("R4 ready low in stall", int'(issue_ready), 0);
    snoop_hit = 1'b1; @(negedge clk); snoop_hit = 1'b0;
    check("R5 snoop ends stall", int'(stall), 0);
    results("R5 snoop result", 1, 0, 0);
    @(negedge clk);
    check("R5 done one cycle", int'(done), 0);
  endtask

  task automatic t_immediate();
    issue(W_STO, PU, 1'b0, 1'b1, 1'b0);
    check("R3 dead resv no stall", int'(stall), 0);
    results("R3 dead resv done", 1, 0, 0);
    give_lr();
    irq_pending = 4'b1000;
    issue(W_NTO, PU, 1'b0, 1'b1, 1'b0);
    irq_pending = '0;
    check("R3 irq at issue no stall", int'(stall), 0);
    results("R3 irq at issue done", 1, 0, 0);
    resv_clear = 1'b1;
    issue(W_NTO, PM, 1'b0, 1'b0, 1'b0);
    resv_clear = 1'b0;
    check("R3 kill same cycle no stall", int'(stall), 0);
    results("R3 kill same cycle done", 1, 0, 0);
    lr_set = 1'b1; resv_clear = 1'b1; @(negedge clk);
    lr_set = 1'b0; resv_clear = 1'b0;
    issue(W_NTO, PM, 1'b0, 1'b0, 1'b0);
    check("R2 kill beats lr", int'(stall), 0);
    results("R2 kill beats lr done", 1, 0, 0);
  endtask

  task automatic t_sto_bound();
    int n;
    give_lr();
    issue(W_STO, PU, 1'b1, 1'b1, 1'b1);
    count_stall(n);
    check("R7 bounded stall length", n, STO);
    results("R7 bounded done", 1, 0, 0);
  endtask

  task automatic t_illegal();
    int n;
    give_lr();
    issue(W_NTO, PU, 1'b0, 1'b1, 1'b0);
    count_stall(n);
    check("R8 trap limit length", n, TRAP);
    results("R8 illegal trap", 0, 1, 0);
    give_lr();
    issue(W_NTO, PS, 1'b1, 1'b1, 1'b1);
    count_stall(n);
    check("R9 tw priority length", n, TRAP);
    results("R9 tw over vtw", 0, 1, 0);
  endtask

  task automatic t_virtual();
    int n;
    give_lr();
    issue(W_NTO, PU, 1'b1, 1'b0, 1'b1);
    count_stall(n);
    check("R9 virtual limit length", n, TRAP);
    results("R9 virtual trap", 0, 0, 1);
  endtask

  task automatic t_no_trap(logic [1:0] p, logic v, logic tw, logic vtw);
    give_lr();
    issue(W_NTO, p, v, tw, vtw);
    repeat (TRAP + 8) @(negedge clk);
    check("R10 still stalled past limit", int'(stall), 1);
    results("R10 no result while waiting", 0, 0, 0);
    irq_pending = 4'b0010; @(negedge clk); irq_pending = '0;
    check("R6 irq ends stall", int'(stall), 0);
    results("R6 irq done", 1, 0, 0);
  endtask

  task automatic t_early();
    give_lr();
    issue(W_NTO, PU, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    early_wake = 1'b1; @(negedge clk); early_wake = 1'b0;
    check("R11 early wake stall", int'(stall), 0);
    results("R11 early wake done", 1, 0, 0);
  endtask

  task automatic t_race();
    give_lr();
    issue(W_NTO, PU, 1'b0, 1'b1, 1'b0);
    repeat (TRAP - 1) @(negedge clk);
    check("R12 stalled in last cycle", int'(stall), 1);
    irq_pending = 4'b0001; @(negedge clk); irq_pending = '0;
    check("R12 race stall", int'(stall), 0);
    results("R12 wake beats trap", 1, 0, 0);
    give_lr();
    issue(W_STO, PU, 1'b0, 1'b0, 1'b0);
    repeat (STO - 1) @(negedge clk);
    early_wake = 1'b1; @(negedge clk); early_wake = 1'b0;
    results("R12 wake at bound single done", 1, 0, 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_immediate();
    t_sto_bound();
    t_illegal();
    t_virtual();
    t_no_trap(PM, 1'b1, 1'b1, 1'b1);
    t_no_trap(PU, 1'b0, 1'b0, 1'b1);
    t_early();
    t_race();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end
endmodule